// File: doc/BRIEF.md
# Converter Link Transmit Sequencer

This block is the transmit side of the link layer for a multi-lane 8b/10b converter link. Each lane carries one 32-bit word per link clock, which holds four octets, and a four-bit flag that marks which of those octets are control characters. The flags are passed to the encoder further down the chain. This block does no encoding, no scrambling and no serialisation.

While the receiver holds its active-low synchronisation request, every active lane sends comma characters. After the request is released, commas continue for a minimum number of octets and then until a multiframe boundary. The block then sends a four-multiframe alignment sequence. Every multiframe opens with a start marker and closes with an end marker. The second multiframe also carries a configuration marker and fourteen configuration octets. After the last end marker, user words pass straight through. If the request comes back for long enough during alignment or user data, the link drops to commas and a sticky error flag is set.

The link parameters (active lane count L, octets per frame F, frames per multiframe K) and the configuration octets are inputs. They are sampled only while commas are being sent under an active request. The multiframe boundary comes from an external counter as a one-cycle-early pulse.

Top module: `tx_link_seq`

## Requirements
- R1: In the comma phase, every octet of every active lane is 0xBC with its control flag set. After reset the block is in the comma phase, with one active lane, F=1, K=32, all configuration octets zero and `link_err` low.
- R2: Lane n occupies `lane_data[32n+31:32n]`. Octet j of that word sits at bits [8j+7:8j] and is octet j in transmission order. Its control flag is `lane_ctrl[4n+j]`.
- R3: A control flag is set only on the characters 0xBC, 0x1C, 0x9C and 0x7C when the sequencer itself emits them. User and ramp octets always carry a clear flag, even when their value equals one of those codes.
- R4: Once `sync_n` is high, alignment starts in the cycle after one in which `mf_boundary` is high and the count of commas sent with `sync_n` high, including that cycle's four, has reached F+9. A boundary pulse that arrives before that count is reached is ignored. A low `sync_n` in the comma phase clears the count.
- R5: The alignment sequence lasts exactly four multiframes of K*F octets each. Octet 0 of each multiframe is 0x1C and the last octet is 0x7C.
- R6: In the second multiframe, octet 1 is 0x9C and octets 2 to 15 are configuration octets 0 to 13, where octet i is `cfg_octets[8i+7:8i]`. Every other alignment octet that is not a marker carries its position within the multiframe, modulo 256.
- R7: From the word after the last 0x7C, each active lane outputs its `tx_data` word unchanged, with all control flags clear.
- R8: During alignment or user data, `sync_n` low for a run that has covered fewer than 5*F octets (four per cycle) changes nothing. In the cycle where the run reaches 5*F octets, that cycle's word is still sent. From the next cycle the block is in the comma phase and `link_err` is high. `link_err` stays high until reset.
- R9: Lanes with index L or above output all-zero data and clear control flags.
- R10: L, F, K and the configuration octets are captured on every clock spent in the comma phase with `sync_n` low. Changes to them at any other time have no effect.
- R11: `ilas_reg0` holds captured configuration octets 0 to 3 and `ilas_reg1` holds octets 4 to 7, with the lower-numbered octet in the lower bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Synchronisation request from the receiver, active low |
| mf_boundary | input | 1 | High in the cycle before the first word of a multiframe |
| cfg_lanes | input | 4 | Active lane count L, 1 to MAX_LANES |
| cfg_f | input | 3 | Octets per frame F: 1, 2 or 4 |
| cfg_k | input | 6 | Frames per multiframe K; K*F must be a multiple of 4 and at least 20 |
| cfg_octets | input | 112 | Fourteen configuration octets, octet i at [8i+7:8i] |
| tx_data | input | 32*MAX_LANES | User words, one per lane |
| lane_data | output | 32*MAX_LANES | Transmitted lane words |
| lane_ctrl | output | 4*MAX_LANES | Per-octet control-character flags |
| link_err | output | 1 | Sticky resynchronisation error |
| ilas_reg0 | output | 32 | Captured configuration octets 0 to 3 |
| ilas_reg1 | output | 32 | Captured configuration octets 4 to 7 |

## Verification
The assertions check the following on every cycle:
- the comma fill of active lanes whenever the sequencer is in the comma phase;
- that a control flag never marks a non-control value;
- that lanes above L stay quiet;
- that each alignment sequence opens with a start marker;
- that the error flag rises only together with a return to commas and never falls afterwards.

The placement of the markers, the configuration octets and the ramp over the four multiframes can only be shown by the scenario scoreboard. The same applies to the exact boundary on which alignment is accepted or rejected, the frame-count threshold for a dropped request under different F, and the rule that parameters change only while a request is held.

// File: rtl/tx_seq_pkg.sv
// Shared types and character codes for the transmit link sequencer.
// Assumes four octets per lane word and fourteen configuration octets.
package tx_seq_pkg;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_ALIGN = 2'd1,
        PH_USER  = 2'd2
    } phase_e;

    localparam int WORD_OCT = 4;
    localparam int CFG_OCT  = 14;

    localparam logic [7:0] CH_COMMA = 8'hBC;
    localparam logic [7:0] CH_START = 8'h1C;
    localparam logic [7:0] CH_CFG   = 8'h9C;
    localparam logic [7:0] CH_END   = 8'h7C;

endpackage

// File: rtl/tx_seq_ctrl.sv
// Phase controller: holds the link phase, the position inside the alignment
// sequence, the captured link parameters and the sticky error flag.
// Assumes mf_boundary is a one-cycle-early multiframe pulse and that the
// captured K*F is a multiple of four.
module tx_seq_ctrl
    import tx_seq_pkg::*;
#(
    parameter int MAX_LANES     = 8,
    parameter int MAX_K         = 32,
    parameter int RESYNC_FRAMES = 5,
    parameter int CNT_W         = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_n,
    input  logic                        mf_boundary,
    input  logic [$clog2(MAX_LANES+1)-1:0] cfg_lanes,
    input  logic [2:0]                  cfg_f,
    input  logic [$clog2(MAX_K+1)-1:0]  cfg_k,
    input  logic [8*CFG_OCT-1:0]        cfg_octets,
    output phase_e                      phase,
    output logic [$clog2(MAX_K*4+1)-3:0] word_idx,
    output logic [1:0]                  mf_idx,
    output logic [$clog2(MAX_K*4+1)-1:0] last_oct,
    output logic [$clog2(MAX_LANES+1)-1:0] act_lanes,
    output logic [8*CFG_OCT-1:0]        cfg_q,
    output logic                        err_flag
);
    localparam int LW    = $clog2(MAX_LANES+1);
    localparam int KW    = $clog2(MAX_K+1);
    localparam int MFO_W = $clog2(MAX_K*4+1);
    localparam int WI_W  = MFO_W - 2;

    logic [KW-1:0]    cap_k;
    logic [2:0]       cap_f;
    logic [CNT_W-1:0] hi_oct;
    logic [CNT_W-1:0] lo_oct;
    logic [MFO_W-1:0] mf_oct;
    logic [WI_W-1:0]  word_last;
    logic [CNT_W:0]   hi_sum, lo_sum, hi_need, lo_need;
    logic             hi_ok, lo_trip;

    // Saturating add of one word's worth of octets.
    function automatic logic [CNT_W-1:0] sat_add4(input logic [CNT_W-1:0] v);
        logic [CNT_W:0] s;
        s = {1'b0, v} + (CNT_W+1)'(WORD_OCT);
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction

    // Multiframe geometry and the two octet thresholds.
    always_comb begin
        mf_oct    = MFO_W'(cap_k) * MFO_W'(cap_f);
        last_oct  = mf_oct - MFO_W'(1);
        word_last = last_oct[MFO_W-1:2];
        hi_sum    = {1'b0, hi_oct} + (CNT_W+1)'(WORD_OCT);
        lo_sum    = {1'b0, lo_oct} + (CNT_W+1)'(WORD_OCT);
        hi_need   = (CNT_W+1)'(cap_f) + (CNT_W+1)'(9);
        lo_need   = (CNT_W+1)'(RESYNC_FRAMES) * (CNT_W+1)'(cap_f);
        hi_ok     = hi_sum >= hi_need;
        lo_trip   = !sync_n && (lo_sum >= lo_need);
    end

    // Phase sequencing, octet counters, parameter capture and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_COMMA;
            word_idx  <= '0;
            mf_idx    <= '0;
            hi_oct    <= '0;
            lo_oct    <= '0;
            err_flag  <= 1'b0;
            act_lanes <= LW'(1);
            cap_f     <= 3'd1;
            cap_k     <= KW'(32);
            cfg_q     <= '0;
        end else begin
            case (phase)
                PH_COMMA: begin
                    lo_oct   <= '0;
                    word_idx <= '0;
                    mf_idx   <= '0;
                    if (!sync_n) begin
                        hi_oct    <= '0;
                        act_lanes <= cfg_lanes;
                        cap_f     <= cfg_f;
                        cap_k     <= cfg_k;
                        cfg_q     <= cfg_octets;
                    end else if (hi_ok && mf_boundary) begin
                        hi_oct <= '0;
                        phase  <= PH_ALIGN;
                    end else begin
                        hi_oct <= sat_add4(hi_oct);
                    end
                end
                default: begin
                    if (lo_trip) begin
                        phase    <= PH_COMMA;
                        err_flag <= 1'b1;
                        lo_oct   <= '0;
                        hi_oct   <= '0;
                    end else begin
                        lo_oct <= sync_n ? '0 : sat_add4(lo_oct);
                        if (phase == PH_ALIGN) begin
                            if (word_idx == word_last) begin
                                word_idx <= '0;
                                mf_idx   <= mf_idx + 2'd1;
                                if (mf_idx == 2'd3) phase <= PH_USER;
                            end else begin
                                word_idx <= word_idx + WI_W'(1);
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tx_octet_gen.sv
// Single-octet selector: picks the comma, a marker, a configuration octet,
// the position ramp or the user octet for one octet slot of one lane.
// Assumes the caller supplies the octet's position inside the multiframe.
module tx_octet_gen
    import tx_seq_pkg::*;
#(
    parameter int MFO_W = 8
) (
    input  phase_e               phase,
    input  logic [MFO_W-1:0]     pos,
    input  logic [MFO_W-1:0]     last_oct,
    input  logic [1:0]           mf_idx,
    input  logic [8*CFG_OCT-1:0] cfg_q,
    input  logic [7:0]           user_oct,
    input  logic                 lane_on,
    output logic [7:0]           oct,
    output logic                 is_k
);
    logic [3:0] ci;

    // Octet content for the current phase and position.
    always_comb begin
        ci   = 4'(pos - MFO_W'(2));
        oct  = 8'h00;
        is_k = 1'b0;
        if (lane_on) begin
            case (phase)
                PH_COMMA: begin
                    oct  = CH_COMMA;
                    is_k = 1'b1;
                end
                PH_USER: oct = user_oct;
                PH_ALIGN: begin
                    if (pos == '0) begin
                        oct  = CH_START;
                        is_k = 1'b1;
                    end else if (pos == last_oct) begin
                        oct  = CH_END;
                        is_k = 1'b1;
                    end else if (mf_idx == 2'd1 && pos == MFO_W'(1)) begin
                        oct  = CH_CFG;
                        is_k = 1'b1;
                    end else if (mf_idx == 2'd1 && pos <= MFO_W'(CFG_OCT + 1)) begin
                        oct = cfg_q[{ci, 3'b000} +: 8];
                    end else begin
                        oct = 8'(pos);
                    end
                end
                default: oct = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/tx_lane_word.sv
// One lane's 32-bit word: four octet selectors, octet j at bits [8j+7:8j].
// Assumes a word index counted in whole words within the multiframe.
module tx_lane_word
    import tx_seq_pkg::*;
#(
    parameter int MFO_W = 8
) (
    input  phase_e               phase,
    input  logic [MFO_W-3:0]     word_idx,
    input  logic [1:0]           mf_idx,
    input  logic [MFO_W-1:0]     last_oct,
    input  logic [8*CFG_OCT-1:0] cfg_q,
    input  logic [8*WORD_OCT-1:0] user_word,
    input  logic                 lane_on,
    output logic [8*WORD_OCT-1:0] word,
    output logic [WORD_OCT-1:0]  kflags
);
    for (genvar j = 0; j < WORD_OCT; j++) begin : g_oct
        tx_octet_gen #(.MFO_W(MFO_W)) oct_i (
            .phase    (phase),
            .pos      ({word_idx, 2'(j)}),
            .last_oct (last_oct),
            .mf_idx   (mf_idx),
            .cfg_q    (cfg_q),
            .user_oct (user_word[8*j +: 8]),
            .lane_on  (lane_on),
            .oct      (word[8*j +: 8]),
            .is_k     (kflags[j])
        );
    end

endmodule

// File: rtl/tx_link_seq.sv
// Top of the transmit link sequencer: one phase controller drives all lanes.
// Assumes static link parameters during a link session and a one-cycle-early
// multiframe pulse. Lane outputs follow registered state combinationally.
module tx_link_seq
    import tx_seq_pkg::*;
#(
    parameter int MAX_LANES     = 8,
    parameter int MAX_K         = 32,
    parameter int RESYNC_FRAMES = 5,
    parameter int CNT_W         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sync_n,
    input  logic                              mf_boundary,
    input  logic [$clog2(MAX_LANES+1)-1:0]    cfg_lanes,
    input  logic [2:0]                        cfg_f,
    input  logic [$clog2(MAX_K+1)-1:0]        cfg_k,
    input  logic [8*CFG_OCT-1:0]              cfg_octets,
    input  logic [8*WORD_OCT*MAX_LANES-1:0]   tx_data,
    output logic [8*WORD_OCT*MAX_LANES-1:0]   lane_data,
    output logic [WORD_OCT*MAX_LANES-1:0]     lane_ctrl,
    output logic                              link_err,
    output logic [31:0]                       ilas_reg0,
    output logic [31:0]                       ilas_reg1
);
    localparam int LW    = $clog2(MAX_LANES+1);
    localparam int MFO_W = $clog2(MAX_K*4+1);
    localparam int LWORD = 8*WORD_OCT;

    phase_e               phase;
    logic [MFO_W-3:0]     word_idx;
    logic [1:0]           mf_idx;
    logic [MFO_W-1:0]     last_oct;
    logic [LW-1:0]        act_lanes;
    logic [8*CFG_OCT-1:0] cfg_q;

    tx_seq_ctrl #(
        .MAX_LANES(MAX_LANES), .MAX_K(MAX_K),
        .RESYNC_FRAMES(RESYNC_FRAMES), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mf_boundary(mf_boundary),
        .cfg_lanes(cfg_lanes), .cfg_f(cfg_f), .cfg_k(cfg_k), .cfg_octets(cfg_octets),
        .phase(phase), .word_idx(word_idx), .mf_idx(mf_idx), .last_oct(last_oct),
        .act_lanes(act_lanes), .cfg_q(cfg_q), .err_flag(link_err)
    );

    for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
        tx_lane_word #(.MFO_W(MFO_W)) lane_i (
            .phase     (phase),
            .word_idx  (word_idx),
            .mf_idx    (mf_idx),
            .last_oct  (last_oct),
            .cfg_q     (cfg_q),
            .user_word (tx_data[LWORD*n +: LWORD]),
            .lane_on   (LW'(n) < act_lanes),
            .word      (lane_data[LWORD*n +: LWORD]),
            .kflags    (lane_ctrl[WORD_OCT*n +: WORD_OCT])
        );
    end

    assign ilas_reg0 = cfg_q[31:0];
    assign ilas_reg1 = cfg_q[63:32];

endmodule

// File: rtl/tx_link_seq_chk.sv
// Property checker for tx_link_seq, attached by bind. Observes the phase
// and the captured lane count next to the lane outputs.
module tx_link_seq_chk
    import tx_seq_pkg::*;
#(
    parameter int MAX_LANES = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input phase_e                         phase,
    input logic [$clog2(MAX_LANES+1)-1:0] act_lanes,
    input logic [32*MAX_LANES-1:0]        lane_data,
    input logic [4*MAX_LANES-1:0]         lane_ctrl,
    input logic                           link_err
);
    logic comma_ok, k_bad, idle_bad;

    // Summaries over all lanes and octets.
    always_comb begin
        comma_ok = 1'b1;
        k_bad    = 1'b0;
        idle_bad = 1'b0;
        for (int n = 0; n < MAX_LANES; n++) begin
            for (int j = 0; j < 4; j++) begin
                if (n < int'(act_lanes)) begin
                    if (lane_data[32*n+8*j +: 8] != CH_COMMA || !lane_ctrl[4*n+j])
                        comma_ok = 1'b0;
                end else if (lane_data[32*n+8*j +: 8] != 8'h00 || lane_ctrl[4*n+j]) begin
                    idle_bad = 1'b1;
                end
                if (lane_ctrl[4*n+j] &&
                    !(lane_data[32*n+8*j +: 8] inside {CH_COMMA, CH_START, CH_CFG, CH_END}))
                    k_bad = 1'b1;
            end
        end
    end

    a_r1_comma_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COMMA) |-> comma_ok);

    a_r3_flag_only_on_control: assert property (@(posedge clk) disable iff (!rst_n)
        !k_bad);

    a_r9_idle_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_bad);

    a_r5_align_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ALIGN && $past(phase) == PH_COMMA) |->
            (lane_data[7:0] == CH_START && lane_ctrl[0]));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> link_err);

    a_r8_err_with_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> (phase == PH_COMMA));

endmodule

bind tx_link_seq tx_link_seq_chk #(.MAX_LANES(MAX_LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .act_lanes(act_lanes),
    .lane_data(lane_data), .lane_ctrl(lane_ctrl), .link_err(link_err)
);

// File: tb/tx_link_seq_tb_top.sv
// Scoreboard bench: the driver pushes one expected item per cycle, the
// monitor pops it just before the next rising edge and compares.
module tx_link_seq_tb_top;

    typedef struct {
        logic [255:0] d;
        logic [31:0]  k;
        logic         er;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_n = 1'b0;
    logic         mf_boundary = 1'b0;
    logic [3:0]   cfg_lanes = 4'd2;
    logic [2:0]   cfg_f = 3'd1;
    logic [5:0]   cfg_k = 6'd32;
    logic [111:0] cfg_octets = '0;
    logic [255:0] tx_data = '0;
    logic [255:0] lane_data;
    logic [31:0]  lane_ctrl;
    logic         link_err;
    logic [31:0]  ilas_reg0, ilas_reg1;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [111:0] cfg_a, cfg_c;

    always #5 clk = ~clk;

    tx_link_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mf_boundary(mf_boundary),
        .cfg_lanes(cfg_lanes), .cfg_f(cfg_f), .cfg_k(cfg_k), .cfg_octets(cfg_octets),
        .tx_data(tx_data), .lane_data(lane_data), .lane_ctrl(lane_ctrl),
        .link_err(link_err), .ilas_reg0(ilas_reg0), .ilas_reg1(ilas_reg1)
    );

    // Expected words from the requirements (R1, R2, R5, R6, R7, R9).
    function automatic exp_t mk_comma(int l, string t, logic er);
        exp_t e;
        e.d = '0; e.k = '0; e.er = er; e.tag = t;
        for (int n = 0; n < l; n++) begin
            e.d[32*n +: 32] = 32'hBCBCBCBC;
            e.k[4*n +: 4]   = 4'hF;
        end
        return e;
    endfunction

    function automatic exp_t mk_ila(int l, int m, int w, int mfo,
                                    logic [111:0] cfg, string t, logic er);
        exp_t e;
        e.d = '0; e.k = '0; e.er = er; e.tag = t;
        for (int n = 0; n < l; n++) begin
            for (int j = 0; j < 4; j++) begin
                int p;
                logic [7:0] v;
                logic kk;
                p = w*4 + j;
                kk = 1'b0;
                if (p == 0) begin v = 8'h1C; kk = 1'b1; end
                else if (p == mfo-1) begin v = 8'h7C; kk = 1'b1; end
                else if (m == 1 && p == 1) begin v = 8'h9C; kk = 1'b1; end
                else if (m == 1 && p >= 2 && p <= 15) v = cfg[8*(p-2) +: 8];
                else v = 8'(p);
                e.d[32*n+8*j +: 8] = v;
                e.k[4*n+j]         = kk;
            end
        end
        return e;
    endfunction

    function automatic exp_t mk_data(int l, logic [255:0] d, string t, logic er);
        exp_t e;
        e.d = '0; e.k = '0; e.er = er; e.tag = t;
        for (int n = 0; n < l; n++) e.d[32*n +: 32] = d[32*n +: 32];
        return e;
    endfunction

    // User words that include control-code values in data octets (R3).
    function automatic logic [255:0] dpat(int i);
        logic [255:0] d;
        for (int n = 0; n < 8; n++) d[32*n +: 32] = {8'hBC, 8'(16*i+n), 8'h1C, 8'(n+1)};
        return d;
    endfunction

    task automatic step(logic s, logic b, logic [255:0] d, exp_t e);
        @(negedge clk);
        sync_n = s; mf_boundary = b; tx_data = d;
        q.push_back(e);
    endtask

    task automatic chk_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle, 1 ns before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (lane_data !== e.d || lane_ctrl !== e.k || link_err !== e.er) begin
                    n_fail++;
                    $display("FAIL %s: actual data=%h ctrl=%h err=%b expected data=%h ctrl=%h err=%b",
                             e.tag, lane_data, lane_ctrl, link_err, e.d, e.k, e.er);
                end
            end
        end
    end

    // Driver: scenarios.
    initial begin
        for (int i = 0; i < 14; i++) begin
            cfg_a[8*i +: 8] = 8'(8'h40 + i);
            cfg_c[8*i +: 8] = 8'(8'hC0 ^ (i*7));
        end
        cfg_octets = cfg_a;
        repeat (3) @(negedge clk);

        // Reset state (R1, R11).
        @(negedge clk);
        rst_n = 1'b1;
        q.push_back(mk_comma(1, "R1 reset state", 1'b0));
        #4;
        chk_val("R11 reset ilas_reg0", ilas_reg0, 32'h0);

        // Scenario A: L=2, F=1, K=32.
        repeat (3) step(1'b0, 1'b0, '0, mk_comma(2, "R1 R9 comma under request", 1'b0));
        #4;
        chk_val("R11 ilas_reg0", ilas_reg0, cfg_a[31:0]);
        chk_val("R11 ilas_reg1", ilas_reg1, cfg_a[63:32]);
        step(1'b1, 1'b0, '0, mk_comma(2, "R4 first released word", 1'b0));
        step(1'b1, 1'b1, '0, mk_comma(2, "R4 early boundary", 1'b0));
        step(1'b1, 1'b1, '0, mk_comma(2, "R4 accepted boundary", 1'b0));
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 8; w++)
                step(1'b1, 1'b0, '0, mk_ila(2, m, w, 32, cfg_a, "R5 R6 alignment F=1", 1'b0));
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b0, dpat(i), mk_data(2, dpat(i), "R7 R3 user data", 1'b0));

        // Scenario B: resync threshold at F=1 (R8).
        step(1'b0, 1'b0, dpat(4), mk_data(2, dpat(4), "R8 short drop", 1'b0));
        step(1'b1, 1'b0, dpat(5), mk_data(2, dpat(5), "R8 short drop ignored", 1'b0));
        step(1'b0, 1'b0, dpat(6), mk_data(2, dpat(6), "R8 drop word 1", 1'b0));
        step(1'b0, 1'b0, dpat(7), mk_data(2, dpat(7), "R8 drop word 2", 1'b0));
        step(1'b0, 1'b0, '0, mk_comma(2, "R8 comma after trip", 1'b1));
        cfg_lanes = 4'd4; cfg_f = 3'd2; cfg_octets = cfg_c;
        step(1'b0, 1'b0, '0, mk_comma(4, "R10 recapture", 1'b1));
        #4;
        chk_val("R11 ilas_reg1 recaptured", ilas_reg1, cfg_c[63:32]);

        // Scenario C: L=4, F=2, K=32; parameter change while released (R10).
        step(1'b1, 1'b0, '0, mk_comma(4, "R4 F=2 first released word", 1'b1));
        cfg_lanes = 4'd8; cfg_octets = cfg_a;
        step(1'b1, 1'b1, '0, mk_comma(4, "R4 F=2 early boundary", 1'b1));
        step(1'b1, 1'b1, '0, mk_comma(4, "R4 F=2 accepted boundary", 1'b1));
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 16; w++)
                step(1'b1, 1'b0, '0, mk_ila(4, m, w, 64, cfg_c, "R5 R6 R10 alignment F=2", 1'b1));
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b0, dpat(i+8), mk_data(4, dpat(i+8), "R7 R9 user data L=4", 1'b1));
        #4;
        chk_val("R10 ilas_reg0 held", ilas_reg0, cfg_c[31:0]);
        step(1'b0, 1'b0, dpat(11), mk_data(4, dpat(11), "R8 F=2 drop word 1", 1'b1));
        step(1'b0, 1'b0, dpat(12), mk_data(4, dpat(12), "R8 F=2 drop word 2", 1'b1));
        step(1'b1, 1'b0, dpat(13), mk_data(4, dpat(13), "R8 F=2 below threshold", 1'b1));

        @(negedge clk);
        #5;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule